// File: doc/BRIEF.md
# Color-Packed Accumulator Unit

This unit keeps running per-channel totals for luminance/chrominance pixel data packed two pixels to a 32-bit word. Each operand word carries two 16-bit pixels. Each pixel holds a 6-bit luma value and two 5-bit chroma values. On every valid command the unit either folds per-channel absolute differences or per-channel products of its two operands into six independent totals, clears all totals, or copies one 32-bit slice of the packed total register into its read register.

The six totals live side by side in one 128-bit register. Each is a 21-bit unsigned field, which is far wider than any single contribution (at most 12 bits). Motion-estimation distortion sums and short dot products can therefore run over many pixels without overflow. Sums across channels are left to software, which reads the four slices and extracts the fields.

Top module: `cpacc_unit`

## Requirements
- R1: After reset the read output is zero, and every slice read before any accumulate returns zero.
- R2: Operand lanes are taken per 16-bit half: luma in bits [5:0], first chroma in bits [10:6], second chroma in bits [15:11]. The second pixel uses the same layout in bits [31:16]. Lane numbers 0..5 run luma0, chroma-a0, chroma-b0, luma1, chroma-a1, chroma-b1.
- R3: Lane k's total occupies packed bits [21k+20:21k]. Bits 127:126 always read as zero, so bits [31:30] of slice 3 are zero.
- R4: Opcode 2'b01 with valid adds the unsigned absolute difference |a-b| of each lane to that lane's total.
- R5: Opcode 2'b10 with valid adds the unsigned product a*b of each lane to that lane's total.
- R6: Each total wraps modulo 2^21. No saturation is applied, and a wrap in one lane does not disturb its neighbours.
- R7: Opcode 2'b11 with valid clears all six totals.
- R8: Opcode 2'b00 with valid loads packed bits [32k+31:32k] into the read output on that clock edge, where k is the slice select. The read output holds its value until the next valid read.
- R9: With valid low, neither the totals nor the read output change, whatever the opcode, slice select or operands.
- R10: An accumulate or clear takes effect on the clock edge that samples it, so a read issued in the very next cycle returns the updated total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid_i | input | 1 | Command strobe; the command is sampled on the rising edge |
| opcode_i | input | 2 | 00 read, 01 absolute-difference accumulate, 10 multiply accumulate, 11 clear |
| slice_sel_i | input | 2 | Which 32-bit slice a read returns |
| opnd_a_i | input | 32 | First packed two-pixel operand |
| opnd_b_i | input | 32 | Second packed two-pixel operand |
| rd_data_o | output | 32 | Registered read value |

## Verification
The totals are visible only through read commands. A corrupted lane field therefore shows up as a wrong value in whichever slices that field spans, one cycle after the read is issued. A field that crosses a slice boundary has to be read through both slices to expose a misplaced bit. The bench reads all four slices after random command bursts. A wrong operand lane mapping or a wrong absolute-difference direction appears at the first read after one accumulate. A missing modulo wrap, or a carry that leaks into the next field, appears only after more than 2^21 worth of contributions. For that reason a long run of maximum products is replayed.

// File: rtl/cpacc_pkg.sv
package cpacc_pkg;
  typedef enum logic [1:0] {
    OP_READ = 2'b00,
    OP_ABSD = 2'b01,
    OP_MAC  = 2'b10,
    OP_ZERO = 2'b11
  } cpacc_op_e;

  // Bit offset of a component inside one packed pixel (0 luma, 1/2 chroma)
  function automatic int comp_lsb(int comp, int y_w, int c_w);
    return (comp == 0) ? 0 : ((comp == 1) ? y_w : y_w + c_w);
  endfunction
endpackage

// File: rtl/cpacc_lane.sv
module cpacc_lane #(
  parameter int SRC_W   = 6,
  parameter int FIELD_W = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_en_i,
  input  logic               clr_i,
  input  logic               mac_sel_i,
  input  logic [SRC_W-1:0]   a_i,
  input  logic [SRC_W-1:0]   b_i,
  output logic [FIELD_W-1:0] field_o
);
  localparam int PROD_W = 2 * SRC_W;

  logic [SRC_W-1:0]   diff;
  logic [PROD_W-1:0]  prod;
  logic [PROD_W-1:0]  incr;
  logic [FIELD_W-1:0] field_d;
  logic [FIELD_W-1:0] field_q;
  logic               field_en;

  // next-state
  always_comb begin
    diff     = (a_i >= b_i) ? (a_i - b_i) : (b_i - a_i);
    prod     = PROD_W'(a_i) * PROD_W'(b_i);
    incr     = mac_sel_i ? prod : PROD_W'(diff);
    field_en = clr_i | acc_en_i;
    field_d  = clr_i ? '0 : (field_q + FIELD_W'(incr));
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        field_q <= '0;
    else if (field_en) field_q <= field_d;
  end

  assign field_o = field_q;
endmodule

// File: rtl/cpacc_rdmux.sv
module cpacc_rdmux #(
  parameter int ACC_W = 128,
  parameter int RD_W  = 32,
  localparam int SLICES = ACC_W / RD_W,
  localparam int SEL_W  = $clog2(SLICES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [RD_W-1:0]  rd_o
);
  logic [RD_W-1:0] rd_d;
  logic [RD_W-1:0] rd_q;

  always_comb rd_d = acc_i[sel_i*RD_W +: RD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rd_o = rd_q;
endmodule

// File: rtl/cpacc_unit.sv
module cpacc_unit #(
  parameter int Y_W     = 6,
  parameter int C_W     = 5,
  parameter int FIELD_W = 21,
  parameter int ACC_W   = 128,
  parameter int RD_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         op_valid_i,
  input  logic [1:0]                   opcode_i,
  input  logic [$clog2(ACC_W/RD_W)-1:0] slice_sel_i,
  input  logic [2*(Y_W+2*C_W)-1:0]     opnd_a_i,
  input  logic [2*(Y_W+2*C_W)-1:0]     opnd_b_i,
  output logic [RD_W-1:0]              rd_data_o
);
  import cpacc_pkg::*;

  localparam int PIX_W  = Y_W + 2 * C_W;
  localparam int LANES  = 6;
  localparam int USED_W = LANES * FIELD_W;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  cpacc_op_e          op;
  logic               acc_en;
  logic               clr;
  logic               mac_sel;
  logic               rd_en;
  logic [ACC_W-1:0]   acc_packed;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // command decode
  always_comb begin
    op      = cpacc_op_e'(opcode_i);
    acc_en  = op_valid_i && ((op == OP_ABSD) || (op == OP_MAC));
    mac_sel = (op == OP_MAC);
    clr     = op_valid_i && (op == OP_ZERO);
    rd_en   = op_valid_i && (op == OP_READ);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int PIX  = g / 3;
    localparam int COMP = g % 3;
    localparam int SW   = (COMP == 0) ? Y_W : C_W;
    localparam int LSB  = PIX * PIX_W + comp_lsb(COMP, Y_W, C_W);

    logic [FIELD_W-1:0] field;

    cpacc_lane #(.SRC_W(SW), .FIELD_W(FIELD_W)) lane_i (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .acc_en_i  (acc_en),
      .clr_i     (clr),
      .mac_sel_i (mac_sel),
      .a_i       (opnd_a_i[LSB +: SW]),
      .b_i       (opnd_b_i[LSB +: SW]),
      .field_o   (field)
    );
    assign acc_packed[g*FIELD_W +: FIELD_W] = field;
  end

  if (ACC_W > USED_W) begin : g_pad
    assign acc_packed[ACC_W-1:USED_W] = '0;
  end

  cpacc_rdmux #(.ACC_W(ACC_W), .RD_W(RD_W)) rdmux_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rd_en_i (rd_en),
    .sel_i   (slice_sel_i),
    .acc_i   (acc_packed),
    .rd_o    (rd_data_o)
  );
endmodule

// File: rtl/cpacc_chk.sv
module cpacc_chk #(
  parameter int FIELD_W = 21
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid_i,
  input logic [1:0]   opcode_i,
  input logic [1:0]   slice_sel_i,
  input logic [31:0]  opnd_a_i,
  input logic [31:0]  opnd_b_i,
  input logic [31:0]  rd_data_o,
  input logic [127:0] acc_packed
);
  function automatic logic [FIELD_W-1:0] absd6(logic [5:0] a, logic [5:0] b);
    return (a >= b) ? FIELD_W'(a - b) : FIELD_W'(b - a);
  endfunction

  function automatic logic [FIELD_W-1:0] mul5(logic [4:0] a, logic [4:0] b);
    return FIELD_W'(a) * FIELD_W'(b);
  endfunction

  // R7
  a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && opcode_i == 2'b11) |=> (acc_packed == '0));

  // R8
  a_r8_read_slice: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && opcode_i == 2'b00) |=>
      (rd_data_o == $past(acc_packed[slice_sel_i*32 +: 32])));

  // R8 / R9
  a_r8_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid_i && opcode_i == 2'b00) |=> $stable(rd_data_o));

  // R9
  a_r9_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> $stable(acc_packed));

  // R4: luma lane of the first pixel
  a_r4_absd_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && opcode_i == 2'b01) |=>
      (acc_packed[FIELD_W-1:0] ==
       $past(acc_packed[FIELD_W-1:0] + absd6(opnd_a_i[5:0], opnd_b_i[5:0]))));

  // R5: second chroma lane of the second pixel
  a_r5_mac_lane5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && opcode_i == 2'b10) |=>
      (acc_packed[5*FIELD_W +: FIELD_W] ==
       $past(acc_packed[5*FIELD_W +: FIELD_W] + mul5(opnd_a_i[31:27], opnd_b_i[31:27]))));
endmodule

bind cpacc_unit cpacc_chk #(.FIELD_W(21)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid_i  (op_valid_i),
  .opcode_i    (opcode_i),
  .slice_sel_i (slice_sel_i),
  .opnd_a_i    (opnd_a_i),
  .opnd_b_i    (opnd_b_i),
  .rd_data_o   (rd_data_o),
  .acc_packed  (acc_packed)
);

// File: tb/cpacc_unit_tb_top.sv
`timescale 1ns/1ps
module cpacc_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        valid;
  logic [1:0]  opc;
  logic [1:0]  sel;
  logic [31:0] a;
  logic [31:0] b;
  logic [31:0] rd;

  int n_chk;
  int n_fail;
  bit done;

  logic [20:0] m [6];

  cpacc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid_i(valid), .opcode_i(opc),
    .slice_sel_i(sel), .opnd_a_i(a), .opnd_b_i(b), .rd_data_o(rd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int lane_lsb(int k);
    int c = k % 3;
    return 16 * (k / 3) + ((c == 0) ? 0 : ((c == 1) ? 6 : 11));
  endfunction

  function automatic int lane_w(int k);
    return (k % 3 == 0) ? 6 : 5;
  endfunction

  function automatic int get_lane(logic [31:0] w, int k);
    return int'((w >> lane_lsb(k)) & ((32'd1 << lane_w(k)) - 1));
  endfunction

  function automatic logic [31:0] mk_word(int v0, int v1, int v2, int v3, int v4, int v5);
    logic [31:0] w = '0;
    int v [6] = '{v0, v1, v2, v3, v4, v5};
    for (int k = 0; k < 6; k++)
      w |= (32'(v[k]) & ((32'd1 << lane_w(k)) - 1)) << lane_lsb(k);
    return w;
  endfunction

  function automatic logic [127:0] model_packed();
    logic [127:0] p = '0;
    for (int k = 0; k < 6; k++) p[21*k +: 21] = m[k];
    return p;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] op, input logic [1:0] s,
                       input logic [31:0] aa, input logic [31:0] bb);
    @(negedge clk);
    valid = v; opc = op; sel = s; a = aa; b = bb;
    @(posedge clk);
    #1;
    valid = 1'b0;
    if (v) begin
      for (int k = 0; k < 6; k++) begin
        int x = get_lane(aa, k);
        int y = get_lane(bb, k);
        case (op)
          2'b01: m[k] = m[k] + 21'((x >= y) ? x - y : y - x);
          2'b10: m[k] = m[k] + 21'(x * y);
          2'b11: m[k] = '0;
          default: ;
        endcase
      end
    end
  endtask

  task automatic read_chk(input logic [1:0] s, input string tag);
    logic [127:0] p = model_packed();
    drive(1'b1, 2'b00, s, $urandom, $urandom);
    chk(rd, p[32*s +: 32], tag);
  endtask

  task automatic read_all(input string tag);
    for (int s = 0; s < 4; s++) read_chk(2'(s), tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    process::self().srandom(32'h5eed_c0de);
    n_chk = 0; n_fail = 0; done = 1'b0;
    for (int k = 0; k < 6; k++) m[k] = '0;
    valid = 0; opc = 0; sel = 0; a = 0; b = 0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1
    chk(rd, 32'h0, "R1 reset read output");
    read_all("R1 slices after reset");

    // R2 / R4: distinct per-lane values, b below a in some lanes and above in others
    drive(1'b1, 2'b01, 0, mk_word(63, 31, 0, 1, 20, 7), mk_word(0, 2, 31, 40, 5, 30));
    read_all("R2 R4 absdiff lane placement");
    // R10: accumulate then immediate read
    drive(1'b1, 2'b01, 0, mk_word(10, 0, 0, 0, 0, 0), mk_word(3, 0, 0, 0, 0, 0));
    read_chk(0, "R10 next-cycle read sees update");

    // R5
    drive(1'b1, 2'b10, 0, mk_word(63, 31, 17, 2, 9, 31), mk_word(63, 31, 3, 50, 9, 31));
    read_all("R5 multiply accumulate");

    // R9: valid low with clear opcode and read opcode
    held = rd;
    drive(1'b0, 2'b11, 2, 32'hffff_ffff, 32'h0);
    drive(1'b0, 2'b00, 3, 32'h0, 32'h0);
    chk(rd, held, "R9 read output unchanged while idle");
    read_all("R9 totals unchanged while idle");

    // R7
    drive(1'b1, 2'b11, 0, $urandom, $urandom);
    read_all("R7 clear");

    // R6 and R3: drive every lane to the maximum product many times
    for (int i = 0; i < 530; i++)
      drive(1'b1, 2'b10, 0, 32'hffff_ffff, 32'hffff_ffff);
    read_all("R6 wrap modulo 2^21");
    chk({30'h0, rd[31:30]}, 32'h0, "R3 pad bits of slice 3 are zero");
    chk(32'(m[0]), 32'd6418, "R6 model wrap value");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 19);
      if (r == 0)      drive(1'b1, 2'b11, 0, $urandom, $urandom);
      else if (r < 3)  read_chk(2'($urandom_range(0, 3)), "R8 random read");
      else if (r < 5)  drive(1'b0, 2'($urandom), 2'($urandom), $urandom, $urandom);
      else             drive(1'b1, 2'($urandom_range(1, 2)), 0, $urandom, $urandom);
      if (i % 50 == 49) read_all("R4 R5 R8 random burst");
    end
    read_all("R3 R8 final slices");

    finish_run();
  end
endmodule